// File: doc/BRIEF.md
# Daisy-Chained Readout Word Source

This block is one slave in a ring of readout sources that take turns on a shared tri-state data bus. Each slave holds a fixed set of 16-bit words, set by a parameter. When the enable coming in from the upstream neighbour goes high, the slave owns the bus. It places one held word on the bus at each rising edge of the beam-crossing clock, lowest index first. It also pulls an active-low strobe low for the second half of each word's cycle.

During the strobe of its final word, the slave raises the enable to its downstream neighbour. That neighbour starts driving at the next rising edge, so the bus moves from slave to slave with no gap and no overlap. When the incoming enable drops, the slave stops driving and releases its outgoing enable at the next falling edge, so teardown ripples around the ring the same way the token did. After its last word, a slave stays silent until the incoming enable has gone low and then high again. A slave built with zero words forwards the enable, one tick late.

Top module: `chain_word_source`

## Requirements
- R1: While the slave owns the bus, each rising edge of `clk` puts the next held word on `bus_data`: word k is `hold_words[16*k+15 : 16*k]`, and the first word after a start is word 0.
- R2: While driving, `bus_valid_n` is 1 in the high phase of each word cycle and 0 in the low phase, giving one low pulse per word that starts at the falling edge.
- R3: `chain_out` rises at the falling edge in the cycle that presents the final word, and stays high while `chain_in` is high.
- R4: `drive_en` is 1 exactly in the cycles in which a word is presented; when it is 0, `bus_data` and `bus_valid_n` are high impedance.
- R5: A low `chain_in` at a falling edge clears `chain_out`.
- R6: After the final word, the slave does not drive again while `chain_in` stays high. It starts over from word 0 only after `chain_in` has been sampled low and then high.
- R7: If `chain_in` is sampled low at a rising edge in the middle of a sequence, driving stops at that edge. The next start begins again at word 0.
- R8: With `NUM_WORDS` = 0, the slave never drives, and `chain_out` takes the value of `chain_in` at each rising edge.
- R9: An asynchronous low `rst_n` at once clears `drive_en` and `chain_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock; words change on rising edges, strobes start on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_in | input | 1 | Enable from the upstream slave, active high |
| hold_words | input | WORD_W*max(NUM_WORDS,1) | Held words, word k in bits [WORD_W*k +: WORD_W] |
| bus_data | output | WORD_W | Shared tri-state data bus |
| bus_valid_n | output | 1 | Shared tri-state active-low data strobe |
| drive_en | output | 1 | High while this slave drives the shared lines |
| chain_out | output | 1 | Enable to the downstream slave, active high |

## Verification
A change in `chain_in` reaches the bus at the next rising edge, one register later. The bench therefore applies each input 2 ns after a rising edge and checks the bus in the high phase of the following cycle. The strobe and `chain_out` come from falling-edge registers, so they are checked 3 ns after the falling edge of that same cycle. In each table row the enable level applied in that row governs the falling-edge outputs, and the previous row's level governs the bus contents. The zero-word variant's one-tick forwarding is checked both before and after the rising edge that should move it.

// File: rtl/chain_word_source.sv
module chain_word_source #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int VEC_W    = WORD_W * ((NUM_WORDS > 0) ? NUM_WORDS : 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_in,
  input  logic [VEC_W-1:0]  hold_words,
  output logic [WORD_W-1:0] bus_data,
  output logic              bus_valid_n,
  output logic              drive_en,
  output logic              chain_out
);

  logic             active;
  logic [IDX_W-1:0] word_idx;

  generate
    if (NUM_WORDS == 0) begin : g_pass
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_out <= 1'b0;
        else        chain_out <= chain_in;

      assign active   = 1'b0;
      assign word_idx = '0;
      assign bus_data    = 'z;
      assign bus_valid_n = 1'bz;
      assign drive_en    = 1'b0;
    end else begin : g_src
      logic run_q, done_q, tog_fall, tog_rise, cout_q;
      logic [IDX_W-1:0] idx_q;
      logic last;

      assign last = (idx_q == IDX_W'(NUM_WORDS - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q  <= 1'b0;
          done_q <= 1'b0;
          idx_q  <= '0;
        end else if (!chain_in) begin
          run_q  <= 1'b0;
          done_q <= 1'b0;
          idx_q  <= '0;
        end else if (run_q) begin
          if (last) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else if (!done_q) begin
          run_q <= 1'b1;
          idx_q <= '0;
        end
      end

      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tog_fall <= 1'b0;
          cout_q   <= 1'b0;
        end else begin
          if (run_q) tog_fall <= ~tog_fall;
          cout_q <= chain_in & (cout_q | (run_q & last));
        end
      end

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tog_rise <= 1'b0;
        else        tog_rise <= tog_fall;

      assign active    = run_q;
      assign word_idx  = idx_q;
      assign chain_out = cout_q;
      assign drive_en  = run_q;
      assign bus_data    = run_q ? hold_words[int'(idx_q)*WORD_W +: WORD_W] : 'z;
      assign bus_valid_n = run_q ? ~(tog_fall ^ tog_rise) : 1'bz;
    end
  endgenerate

endmodule

// File: rtl/word_source_chk.sv
module word_source_chk #(
  parameter int NUM_WORDS = 4,
  parameter int IDX_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chain_in,
  input logic             chain_out,
  input logic             drive_en,
  input logic [IDX_W-1:0] word_idx
);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |=> !drive_en);

  assert_teardown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_in && $past(!chain_in)) |-> !chain_out);

  generate
    if (NUM_WORDS == 0) begin : g_chk_pass
      logic started;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;

      assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> chain_out == $past(chain_in));

      assert_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en);
    end else begin : g_chk_src
      assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en)) |-> word_idx == IDX_W'($past(word_idx) + 1'b1));

      assert_first_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> word_idx == '0);

      assert_token_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_out) |-> drive_en);

      assert_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_out && chain_in) |=> !drive_en);
    end
  endgenerate

endmodule

bind chain_word_source word_source_chk #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(chain_out),
  .drive_en(drive_en), .word_idx(word_idx)
);

// File: tb/tb_chain_word_source.sv
module tb_chain_word_source;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int ROWS = 21;
  // row: {chain_in applied, expect drive, expect chain_out in low phase, expect word index}
  localparam logic [4:0] VEC [ROWS] = '{
    5'b0_0_0_00, 5'b1_0_0_00, 5'b1_1_0_00, 5'b1_1_0_01, 5'b1_1_0_10,
    5'b1_1_1_11, 5'b1_0_1_00, 5'b1_0_1_00, 5'b0_0_0_00, 5'b1_0_0_00,
    5'b1_1_0_00, 5'b1_1_0_01, 5'b0_1_0_10, 5'b0_0_0_00, 5'b1_0_0_00,
    5'b1_1_0_00, 5'b1_1_0_01, 5'b1_1_0_10, 5'b1_1_1_11, 5'b1_0_1_00,
    5'b0_0_0_00 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cin = 1'b0, zin = 1'b0;
  logic [16*N-1:0] words;
  logic [15:0] zwords = 16'h0;
  wire  [15:0] bdata, zdata;
  wire  bvalid_n, zvalid_n;
  logic drv, cout, zdrv, zcout;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_word_source #(.WORD_W(16), .NUM_WORDS(N)) dut (
    .clk(clk), .rst_n(rst_n), .chain_in(cin), .hold_words(words),
    .bus_data(bdata), .bus_valid_n(bvalid_n), .drive_en(drv), .chain_out(cout));

  chain_word_source #(.WORD_W(16), .NUM_WORDS(0)) dut_zero (
    .clk(clk), .rst_n(rst_n), .chain_in(zin), .hold_words(zwords),
    .bus_data(zdata), .bus_valid_n(zvalid_n), .drive_en(zdrv), .chain_out(zcout));

  function automatic logic [15:0] word_of(int i);
    return 16'hA5A0 + 16'(i) * 16'h0111;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) words[16*i +: 16] = word_of(i);
    repeat (3) @(posedge clk);
    #3;
    check("R9 reset drive_en", {15'b0, drv}, 16'h0);
    check("R9 reset chain_out", {15'b0, cout}, 16'h0);
    @(posedge clk); #2 rst_n = 1'b1;

    for (int r = 0; r < ROWS; r++) begin
      @(posedge clk);
      #2 cin = VEC[r][4];
      #1;
      check("R4 drive_en", {15'b0, drv}, {15'b0, VEC[r][3]});
      if (VEC[r][3]) begin
        check("R1 word high phase", bdata, word_of(int'(VEC[r][1:0])));
        check("R2 strobe high phase", {15'b0, bvalid_n}, 16'h1);
      end
      #5;
      if (VEC[r][3]) begin
        check("R1 word low phase", bdata, word_of(int'(VEC[r][1:0])));
        check("R2 strobe low phase", {15'b0, bvalid_n}, 16'h0);
      end
      // rows 6-7 cover R6 idle, rows 12-15 cover R7 abort and restart
      if (VEC[r][2]) check("R3 chain_out", {15'b0, cout}, 16'h1);
      else           check("R5 chain_out", {15'b0, cout}, 16'h0);
    end

    // R6: enable held high long after the final word; bus must stay released
    @(posedge clk); #2 cin = 1'b0;
    @(posedge clk); #2 cin = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #3;
      if (k >= N + 1) check("R6 no repeat", {15'b0, drv}, 16'h0);
    end

    // R9: reset in the middle of a sequence
    @(posedge clk); #2 cin = 1'b0;
    @(posedge clk); #2 cin = 1'b1;
    @(posedge clk); @(posedge clk); #3;
    check("R1 mid word before reset", bdata, word_of(1));
    #1 rst_n = 1'b0;
    #1;
    check("R9 drive_en cleared", {15'b0, drv}, 16'h0);
    check("R9 chain_out cleared", {15'b0, cout}, 16'h0);
    @(posedge clk); #2 rst_n = 1'b1; cin = 1'b0;

    // R8: zero-word slave forwards enable one rising edge later
    @(posedge clk); #2 zin = 1'b1;
    #1 check("R8 not yet forwarded", {15'b0, zcout}, 16'h0);
    @(posedge clk); #3;
    check("R8 forwarded high", {15'b0, zcout}, 16'h1);
    check("R8 never drives", {15'b0, zdrv}, 16'h0);
    @(posedge clk); #2 zin = 1'b0;
    #1 check("R8 still high", {15'b0, zcout}, 16'h1);
    @(posedge clk); #3;
    check("R8 forwarded low", {15'b0, zcout}, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule